// File: doc/BRIEF.md
# Vector-Unit Unavailable Trap Logic

This block sits beside the decode stage of a core and decides whether an issued instruction has to trap because the 64-bit vector and floating-point unit is switched off in the machine state register. It looks at a valid strobe, four instruction-class flags, the instruction address, the current machine state and the two registers that locate the exception handler. It raises a same-cycle suppress signal so the faulting instruction leaves no architectural trace. One cycle later it presents the complete exception entry state, marked by a single-cycle take pulse. That state is the saved PC, the saved status, the new machine state, the syndrome word and the handler fetch address.

The parameter `CORE_REV` picks one of two core variants, and the variants gate different classes. Revision 1 gates SIMD integer, vector single-precision and scalar single-precision instructions. It has no scalar double-precision support. Revision 2 gates SIMD integer, vector single-precision and scalar double-precision instructions. Scalar single-precision instructions never trap on revision 2.

Registers are 32 bits wide, and bits are named in big-endian 64-bit notation: bit n sits at vector index 63-n. The unit-enable bit is 38 (index 25). Critical-interrupt enable is bit 46 (index 17), machine-check enable is bit 51 (index 12) and debug enable is bit 54 (index 9).

Top module: `vu_unavail_trap`

## Requirements
- R1: With `ins_valid`=1 and the enable bit (index 25) of `msr_cur` at 0, an instruction flagged SIMD integer or vector single-precision traps in both variants.
- R2: Scalar double-precision instructions trap under the condition of R1 only when CORE_REV=2; with CORE_REV=1 they never trap.
- R3: Scalar single-precision instructions trap under the condition of R1 only when CORE_REV=1; with CORE_REV=2 they never trap.
- R4: `suppress` is high in the same cycle as a trapping instruction and low otherwise; `take_exc` is high for exactly the one cycle after it.
- R5: On the cycle `take_exc` is high, `saved_pc` equals the `ins_ea` of the trapping instruction.
- R6: On the cycle `take_exc` is high, `saved_stat` equals the full `msr_cur` of the trapping instruction.
- R7: On the cycle `take_exc` is high, `msr_new` equals the trapping `msr_cur` ANDed with mask 32'h0002_1200 (indices 17, 12 and 9 kept, everything else zero).
- R8: On the cycle `take_exc` is high, `syndrome` equals 32'h0000_0080 (big-endian bit 24 of the 32-bit word, index 7, alone set).
- R9: On the cycle `take_exc` is high, `handler_addr` equals {vec_prefix[31:16], vec_offset[15:4], 4'b0000}.
- R10: An invalid instruction, an instruction in no gated class, or any instruction with the enable bit at 1 causes no suppress and no take pulse, and leaves all five state outputs unchanged.
- R11: After reset, `take_exc`, `suppress` and all state outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction issued this cycle |
| cls_simd | input | 1 | SIMD integer class |
| cls_vec_sp | input | 1 | Vector single-precision float class |
| cls_scl_dp | input | 1 | Scalar double-precision float class |
| cls_scl_sp | input | 1 | Scalar single-precision float class |
| ins_ea | input | 32 | Effective address of the instruction |
| msr_cur | input | 32 | Current machine state register |
| vec_prefix | input | 32 | Handler prefix register |
| vec_offset | input | 32 | Per-exception handler offset register |
| suppress | output | 1 | Cancel the instruction (same cycle) |
| take_exc | output | 1 | One-cycle exception-taken pulse |
| saved_pc | output | 32 | Saved program counter |
| saved_stat | output | 32 | Saved machine state |
| msr_new | output | 32 | Machine state on handler entry |
| syndrome | output | 32 | Syndrome register value |
| handler_addr | output | 32 | Handler fetch address |

## Verification
`suppress` is combinational and is due in the stimulus cycle itself. The bench drives inputs on the falling edge and samples `suppress` 1 time unit later, before the next rising edge. `take_exc` and the five state outputs pass through one register each and are due right after the next rising edge, so the bench samples them on the following falling edge. At that point the bench compares each output either with the newly computed entry state or, for a non-trapping stimulus, with the value it held before. The bench sweeps every combination of valid, enable bit and the four class flags against both variants at once.

// File: rtl/vu_unavail_trap.sv
module vu_unavail_trap #(
  parameter int CORE_REV = 2,
  parameter int W        = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ins_valid,
  input  logic         cls_simd,
  input  logic         cls_vec_sp,
  input  logic         cls_scl_dp,
  input  logic         cls_scl_sp,
  input  logic [W-1:0] ins_ea,
  input  logic [W-1:0] msr_cur,
  input  logic [W-1:0] vec_prefix,
  input  logic [W-1:0] vec_offset,
  output logic         suppress,
  output logic         take_exc,
  output logic [W-1:0] saved_pc,
  output logic [W-1:0] saved_stat,
  output logic [W-1:0] msr_new,
  output logic [W-1:0] syndrome,
  output logic [W-1:0] handler_addr
);

  localparam int BE_TOP  = 2*W - 1;
  localparam int IX_EN   = BE_TOP - 38;
  localparam int IX_CE   = BE_TOP - 46;
  localparam int IX_ME   = BE_TOP - 51;
  localparam int IX_DE   = BE_TOP - 54;
  localparam int IX_SYN  = W - 1 - 24;
  localparam logic [W-1:0] KEEP_MASK = (W'(1) << IX_CE) | (W'(1) << IX_ME) | (W'(1) << IX_DE);
  localparam logic [W-1:0] SYN_VAL   = W'(1) << IX_SYN;

  logic gated;

  generate
    if (CORE_REV == 1) begin : g_rev1
      assign gated = cls_simd | cls_vec_sp | cls_scl_sp;
    end else begin : g_rev2
      assign gated = cls_simd | cls_vec_sp | cls_scl_dp;
    end
  endgenerate

  wire unused_bits = ^{vec_prefix[15:0], vec_offset[31:16], vec_offset[3:0],
                       (CORE_REV == 1) ? cls_scl_dp : cls_scl_sp};

  assign suppress = ins_valid & ~msr_cur[IX_EN] & gated;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_exc     <= 1'b0;
      saved_pc     <= '0;
      saved_stat   <= '0;
      msr_new      <= '0;
      syndrome     <= '0;
      handler_addr <= '0;
    end else begin
      take_exc <= suppress;
      if (suppress) begin
        saved_pc     <= ins_ea;
        saved_stat   <= msr_cur;
        msr_new      <= msr_cur & KEEP_MASK;
        syndrome     <= SYN_VAL;
        handler_addr <= {vec_prefix[31:16], vec_offset[15:4], 4'b0000};
      end
    end
  end

  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |=> take_exc);                                                   // R4
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !suppress |=> !take_exc);                                                 // R4
  AST_EN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    msr_cur[IX_EN] |=> !take_exc);                                            // R10
  AST_PC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |=> saved_pc == $past(ins_ea));                                  // R5
  AST_STAT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    suppress |=> saved_stat == $past(msr_cur));                               // R6
  AST_MSR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> (msr_new & ~KEEP_MASK) == '0);                               // R7
  AST_SYN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> $onehot0(syndrome) && syndrome[IX_SYN]);                     // R8
  AST_HANDLER_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> handler_addr[3:0] == 4'b0000);                               // R9
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !suppress |=> $stable(saved_pc) && $stable(saved_stat) && $stable(handler_addr)); // R10

endmodule

// File: tb/vu_unavail_trap_tb.sv
module vu_unavail_trap_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEEP = 32'h0002_1200;
  localparam logic [31:0] SYN  = 32'h0000_0080;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0, c_simd = 1'b0, c_vsp = 1'b0, c_sdp = 1'b0, c_ssp = 1'b0;
  logic [31:0] ea = '0, msr = '0, pfx = '0, ofs = '0;

  logic s2, t2, s1, t1;
  logic [31:0] pc2, st2, mn2, sy2, ha2, pc1, st1, mn1, sy1, ha1;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vu_unavail_trap #(.CORE_REV(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .cls_simd(c_simd), .cls_vec_sp(c_vsp),
    .cls_scl_dp(c_sdp), .cls_scl_sp(c_ssp), .ins_ea(ea), .msr_cur(msr), .vec_prefix(pfx),
    .vec_offset(ofs), .suppress(s2), .take_exc(t2), .saved_pc(pc2), .saved_stat(st2),
    .msr_new(mn2), .syndrome(sy2), .handler_addr(ha2));

  vu_unavail_trap #(.CORE_REV(1)) dut_v1_i (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .cls_simd(c_simd), .cls_vec_sp(c_vsp),
    .cls_scl_dp(c_sdp), .cls_scl_sp(c_ssp), .ins_ea(ea), .msr_cur(msr), .vec_prefix(pfx),
    .vec_offset(ofs), .suppress(s1), .take_exc(t1), .saved_pc(pc1), .saved_stat(st1),
    .msr_new(mn1), .syndrome(sy1), .handler_addr(ha1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [31:0] e_pc[2], e_st[2], e_mn[2], e_sy[2], e_ha[2];

  initial begin
    for (int k = 0; k < 2; k++) begin
      e_pc[k] = '0; e_st[k] = '0; e_mn[k] = '0; e_sy[k] = '0; e_ha[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    chk("R11 take rev2", {31'b0, t2}, 0);
    chk("R11 supp rev2", {31'b0, s2}, 0);
    chk("R11 pc rev2", pc2, 0);
    chk("R11 stat rev1", st1, 0);
    chk("R11 msr rev1", mn1, 0);
    chk("R11 syn rev1", sy1, 0);
    chk("R11 hand rev2", ha2, 0);
    for (int i = 0; i < 64; i++) begin
      logic en, trap2, trap1;
      @(negedge clk);
      ins_valid = i[5];
      en        = i[4];
      {c_simd, c_vsp, c_sdp, c_ssp} = i[3:0];
      ea  = 32'h1000_0000 + 32'(i) * 32'd4 + 32'(i) * 32'h0001_0000;
      msr = (32'hA5C3_5E96 ^ (32'(i) * 32'h0101_0113));
      msr[25] = en;
      pfx = 32'hFFF0_0000 ^ (32'(i) << 16) ^ 32'(i);
      ofs = 32'h0000_0123 * 32'(i + 1) ^ 32'h5A5A_0000;
      trap2 = ins_valid & ~en & (c_simd | c_vsp | c_sdp);   // R1 R2 R3
      trap1 = ins_valid & ~en & (c_simd | c_vsp | c_ssp);   // R1 R2 R3
      #1;
      chk($sformatf("R4 R1 R2 R3 suppress rev2 i=%0d", i), {31'b0, s2}, {31'b0, trap2});
      chk($sformatf("R4 R1 R2 R3 suppress rev1 i=%0d", i), {31'b0, s1}, {31'b0, trap1});
      for (int k = 0; k < 2; k++) begin
        if ((k == 0) ? trap2 : trap1) begin
          e_pc[k] = ea; e_st[k] = msr; e_mn[k] = msr & KEEP; e_sy[k] = SYN;
          e_ha[k] = {pfx[31:16], ofs[15:4], 4'b0000};
        end
      end
      @(posedge clk);
      @(negedge clk);
      ins_valid = 1'b0;
      chk($sformatf("R4 take rev2 i=%0d", i), {31'b0, t2}, {31'b0, trap2});
      chk($sformatf("R4 take rev1 i=%0d", i), {31'b0, t1}, {31'b0, trap1});
      // R5 R6 R7 R8 R9 on trap, R10 hold otherwise
      chk($sformatf("R5 R10 pc rev2 i=%0d", i), pc2, e_pc[0]);
      chk($sformatf("R6 R10 stat rev2 i=%0d", i), st2, e_st[0]);
      chk($sformatf("R7 R10 msr rev2 i=%0d", i), mn2, e_mn[0]);
      chk($sformatf("R8 R10 syn rev2 i=%0d", i), sy2, e_sy[0]);
      chk($sformatf("R9 R10 hand rev2 i=%0d", i), ha2, e_ha[0]);
      chk($sformatf("R5 R10 pc rev1 i=%0d", i), pc1, e_pc[1]);
      chk($sformatf("R6 R10 stat rev1 i=%0d", i), st1, e_st[1]);
      chk($sformatf("R7 R10 msr rev1 i=%0d", i), mn1, e_mn[1]);
      chk($sformatf("R8 R10 syn rev1 i=%0d", i), sy1, e_sy[1]);
      chk($sformatf("R9 R10 hand rev1 i=%0d", i), ha1, e_ha[1]);
    end
    @(negedge clk);
    chk("R4 pulse ends rev2", {31'b0, t2}, 0);
    chk("R4 pulse ends rev1", {31'b0, t1}, 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule